// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block converts a 32-bit virtual data address into a physical address. It uses a small set-associative table of translation entries held in flops. Each entry is a pair of 32-bit words. The match word carries the virtual page tag, a valid flag and an age counter. The translate word carries the physical page number, a cache-inhibit flag and four access-permission flags. A lookup presents the address together with the access kind (read or write) and the privilege level (user or supervisor). The block answers one cycle later with the physical address, the cache-inhibit indication and hit/miss/fault status. For a translating lookup it also names the way in the indexed set that a refill should replace.

Software loads entries through a one-word write port, choosing way, set and word. A probe lookup translates without disturbing the age counters and without raising any miss or fault flag, so a debugger or a page-table walker in software can test an address harmlessly. When translation is switched off, or the translator is reported absent, addresses pass through unchanged. In that case the upper half of the address space is treated as uncached.

Top module: `dtlb_xlate`

## Requirements
- R1: When `xlate_en` is 0 or `mmu_present` is 0, the response gives `rsp_paddr` equal to the request address and `rsp_ci` equal to bit 31 of the request address. `rsp_hit`, `rsp_miss` and `rsp_fault` are 0, `rsp_fault_addr` and `rsp_victim` are 0, and no age counter changes.
- R2: The set index is `vaddr[PAGE_BITS +: log2(SETS)]`. A way matches when bit 0 (valid) of its match word is 1 and match-word bits [31:PAGE_BITS+log2(SETS)] equal the same bits of the address. An address whose tag or set index differs from that of every valid entry misses.
- R3: When several ways of the indexed set match, the lowest-numbered way supplies the translation.
- R4: On a hit that is allowed, `rsp_paddr` is translate-word bits [31:PAGE_BITS] joined with address bits [PAGE_BITS-1:0]. `rsp_ci` is translate-word bit 1, whatever the top address bit is.
- R5: The permission bit is found in the translate word: bit 6 for a user read, bit 7 for a user write, bit 8 for a supervisor read, bit 9 for a supervisor write. If that bit is 0 on a non-probe hit, the response raises `rsp_fault` and sets `rsp_fault_addr` to the virtual address. The translated `rsp_paddr` and `rsp_ci` are still returned.
- R6: A non-probe translating lookup with no matching way raises `rsp_miss` and sets `rsp_fault_addr` to the virtual address. `rsp_paddr` and `rsp_ci` are 0, and no age counter changes.
- R7: Each match word holds an age counter in bits [6 +: log2(SETS)]. A non-probe translating hit reloads the hit way's counter to SETS-1. The same hit decrements by one every other counter in that set that is not zero, and leaves zero counters alone.
- R8: On every translating lookup, `rsp_victim` is the lowest-numbered way of the indexed set whose counter is smallest, taken before any update from that lookup.
- R9: A probe lookup (`req_probe`=1) never raises `rsp_miss` or `rsp_fault` and never changes a counter. On a miss or a permission failure it returns `rsp_paddr`=0 and `rsp_ci`=0. On a permitted hit it returns the same address as a normal lookup. `rsp_hit` reports a match either way.
- R10: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next cycle, and `rsp_valid` is low otherwise.
- R11: A software write sends `sw_data` to the match word (`sw_sel_tr`=0) or the translate word (`sw_sel_tr`=1) of the entry chosen by `sw_way` and `sw_set`. The write takes effect at the next clock edge and wins over a counter update to the same word in that cycle. Reset clears every entry, which leaves all entries invalid with their counters at 0.
- R12: `cfg_word` holds WAYS-1 in bits [1:0] and log2(SETS) in bits [6:3]. All other bits are 0, so the default configuration reads 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation switched on |
| mmu_present | input | 1 | Translator reported present |
| req_valid | input | 1 | Lookup strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_super | input | 1 | 1 for supervisor privilege, 0 for user |
| req_probe | input | 1 | Probe lookup without side effects |
| sw_we | input | 1 | Entry write strobe |
| sw_way | input | 2 | Way of the entry to write |
| sw_set | input | 2 | Set of the entry to write |
| sw_sel_tr | input | 1 | 0 writes the match word, 1 the translate word |
| sw_data | input | 32 | Word to store |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | 32 | Physical address |
| rsp_ci | output | 1 | Access must bypass the cache |
| rsp_hit | output | 1 | A way matched |
| rsp_miss | output | 1 | No way matched (non-probe) |
| rsp_fault | output | 1 | Permission denied (non-probe) |
| rsp_fault_addr | output | 32 | Virtual address of the miss or fault, else 0 |
| rsp_victim | output | 2 | Replacement way for the indexed set |
| cfg_word | output | 32 | Geometry of the table |

## Verification
The age counters can only be seen through the victim way named in a response, so their interplay is the hardest thing to reach from the ports. Reaching it needs a set in which counters differ, zero counters stay put while others fall, and misses and probes leave them alone. The stimulus loads match words with preset counter values, including entries that are invalid but still carry counters. It then alternates hits, misses and probes on that one set, and reads the victim after each step. The scoreboard follows the counters in its own model of the table.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
   localparam int VADDR_W     = 32;
   // match word layout
   localparam int MW_VALID    = 0;
   localparam int MW_AGE_LSB  = 6;
   // translate word layout
   localparam int TW_CI       = 1;
   localparam int TW_U_RD     = 6;
   localparam int TW_U_WR     = 7;
   localparam int TW_S_RD     = 8;
   localparam int TW_S_WR     = 9;

   typedef enum logic {
      SEL_MATCH = 1'b0,
      SEL_XLATE = 1'b1
   } word_sel_e;
endpackage

// File: rtl/dtlb_tag_cmp.sv
module dtlb_tag_cmp
   import dtlb_pkg::*;
#(
   parameter int TAG_LSB = 15
) (
   input  logic [VADDR_W-1:0] entry_mw,
   input  logic [VADDR_W-1:0] lookup_va,
   output logic               way_hit
);
   logic unused_cmp_bits;
   assign unused_cmp_bits = ^{entry_mw[TAG_LSB-1:1], lookup_va[TAG_LSB-1:0]};

   assign way_hit = entry_mw[MW_VALID] &&
                    (entry_mw[VADDR_W-1:TAG_LSB] == lookup_va[VADDR_W-1:TAG_LSB]);
endmodule

// File: rtl/dtlb_perm_chk.sv
module dtlb_perm_chk
   import dtlb_pkg::*;
(
   input  logic [VADDR_W-1:0] entry_tw,
   input  logic               is_write,
   input  logic               is_super,
   output logic               allowed
);
   logic unused_perm_bits;
   assign unused_perm_bits = ^{entry_tw[VADDR_W-1:TW_S_WR+1], entry_tw[TW_U_RD-1:0]};

   always_comb begin
      unique case ({is_super, is_write})
         2'b00:   allowed = entry_tw[TW_U_RD];
         2'b01:   allowed = entry_tw[TW_U_WR];
         2'b10:   allowed = entry_tw[TW_S_RD];
         default: allowed = entry_tw[TW_S_WR];
      endcase
   end
endmodule

// File: rtl/dtlb_age_ctl.sv
module dtlb_age_ctl #(
   parameter int               WAYS   = 4,
   parameter int               AGE_W  = 2,
   parameter int               WAY_W  = 2,
   parameter logic [AGE_W-1:0] RELOAD = '1
) (
   input  logic [WAYS-1:0][AGE_W-1:0] age_in,
   input  logic [WAYS-1:0]            hit_sel,
   output logic [WAYS-1:0][AGE_W-1:0] age_out,
   output logic [WAY_W-1:0]           victim
);
   // aging of one set after a hit
   for (genvar w = 0; w < WAYS; w++) begin : g_age
      always_comb begin
         if (hit_sel[w])
            age_out[w] = RELOAD;
         else if (age_in[w] != '0)
            age_out[w] = age_in[w] - 1'b1;
         else
            age_out[w] = age_in[w];
      end
   end

   // smallest counter, lowest way on ties
   always_comb begin
      logic [AGE_W-1:0] best;
      best   = age_in[0];
      victim = '0;
      for (int w = 1; w < WAYS; w++) begin
         if (age_in[w] < best) begin
            best   = age_in[w];
            victim = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
   import dtlb_pkg::*;
#(
   parameter int PAGE_BITS = 13,
   parameter int SETS      = 4,
   parameter int WAYS      = 4,
   localparam int SET_BITS = $clog2(SETS),
   localparam int SET_W    = (SET_BITS == 0) ? 1 : SET_BITS,
   localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xlate_en,
   input  logic               mmu_present,
   input  logic               req_valid,
   input  logic [VADDR_W-1:0] req_vaddr,
   input  logic               req_write,
   input  logic               req_super,
   input  logic               req_probe,
   input  logic               sw_we,
   input  logic [WAY_W-1:0]   sw_way,
   input  logic [SET_W-1:0]   sw_set,
   input  logic               sw_sel_tr,
   input  logic [VADDR_W-1:0] sw_data,
   output logic               rsp_valid,
   output logic [VADDR_W-1:0] rsp_paddr,
   output logic               rsp_ci,
   output logic               rsp_hit,
   output logic               rsp_miss,
   output logic               rsp_fault,
   output logic [VADDR_W-1:0] rsp_fault_addr,
   output logic [WAY_W-1:0]   rsp_victim,
   output logic [VADDR_W-1:0] cfg_word
);
   localparam int               AGE_W   = (SET_BITS == 0) ? 1 : SET_BITS;
   localparam int               TAG_LSB = PAGE_BITS + SET_BITS;
   localparam logic [AGE_W-1:0] RELOAD  = AGE_W'(SETS - 1);

   // elaboration-time parameter checks
   if ((SETS < 1) || (SETS > 256) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
      $error("SETS must be a power of two from 1 to 256");
   end
   if ((WAYS < 1) || (WAYS > 4)) begin : g_bad_ways
      $error("WAYS must lie between 1 and 4");
   end
   if (MW_AGE_LSB + AGE_W > PAGE_BITS) begin : g_bad_age
      $error("age counter would overlap the page tag");
   end
   if ((TW_S_WR >= PAGE_BITS) || (TAG_LSB > VADDR_W - 1)) begin : g_bad_page
      $error("PAGE_BITS leaves no room for flags or tag");
   end

   assign cfg_word = VADDR_W'((SET_BITS << 3) | (WAYS - 1));

   logic [VADDR_W-1:0] mword [WAYS][SETS];
   logic [VADDR_W-1:0] tword [WAYS][SETS];

   logic [SET_W-1:0] set_idx;
   if (SET_BITS == 0) begin : g_one_set
      assign set_idx = '0;
   end else begin : g_many_sets
      assign set_idx = req_vaddr[PAGE_BITS +: SET_BITS];
   end

   logic [WAYS-1:0]            way_hit;
   logic [WAYS-1:0][AGE_W-1:0] cur_age;
   logic [WAYS-1:0][AGE_W-1:0] next_age;
   logic [WAY_W-1:0]           victim;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [VADDR_W-1:0] cur_mw;
      assign cur_mw     = mword[w][set_idx];
      assign cur_age[w] = cur_mw[MW_AGE_LSB +: AGE_W];
      dtlb_tag_cmp #(.TAG_LSB(TAG_LSB)) u_cmp (
         .entry_mw (cur_mw),
         .lookup_va(req_vaddr),
         .way_hit  (way_hit[w])
      );
   end

   // first matching way wins
   logic [WAYS-1:0]  hit_sel;
   logic [WAY_W-1:0] sel_way;
   logic             any_hit;
   always_comb begin
      hit_sel = '0;
      sel_way = '0;
      any_hit = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_hit[w] && !any_hit) begin
            any_hit    = 1'b1;
            hit_sel[w] = 1'b1;
            sel_way    = WAY_W'(w);
         end
      end
   end

   logic [VADDR_W-1:0] sel_tw;
   logic               perm_ok;
   assign sel_tw = tword[sel_way][set_idx];

   dtlb_perm_chk u_perm (
      .entry_tw(sel_tw),
      .is_write(req_write),
      .is_super(req_super),
      .allowed (perm_ok)
   );

   dtlb_age_ctl #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W), .RELOAD(RELOAD)) u_age (
      .age_in (cur_age),
      .hit_sel(hit_sel),
      .age_out(next_age),
      .victim (victim)
   );

   logic trans_on, do_age;
   assign trans_on = xlate_en && mmu_present;
   assign do_age   = req_valid && trans_on && any_hit && !req_probe;

   // response decode
   logic [VADDR_W-1:0] n_paddr, n_faddr;
   logic               n_ci, n_hit, n_miss, n_fault;
   logic [WAY_W-1:0]   n_victim;
   always_comb begin
      n_paddr  = '0;
      n_faddr  = '0;
      n_ci     = 1'b0;
      n_hit    = 1'b0;
      n_miss   = 1'b0;
      n_fault  = 1'b0;
      n_victim = '0;
      if (!trans_on) begin
         n_paddr = req_vaddr;
         n_ci    = req_vaddr[VADDR_W-1];
      end else begin
         n_victim = victim;
         if (!any_hit) begin
            n_miss  = !req_probe;
            n_faddr = req_probe ? '0 : req_vaddr;
         end else begin
            n_hit = 1'b1;
            if (perm_ok || !req_probe) begin
               n_paddr = {sel_tw[VADDR_W-1:PAGE_BITS], req_vaddr[PAGE_BITS-1:0]};
               n_ci    = sel_tw[TW_CI];
            end
            n_fault = !perm_ok && !req_probe;
            n_faddr = n_fault ? req_vaddr : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) begin
            for (int s = 0; s < SETS; s++) begin
               mword[w][s] <= '0;
               tword[w][s] <= '0;
            end
         end
      end else begin
         if (do_age) begin
            for (int w = 0; w < WAYS; w++)
               mword[w][set_idx][MW_AGE_LSB +: AGE_W] <= next_age[w];
         end
         if (sw_we) begin
            if (sw_sel_tr == SEL_XLATE)
               tword[sw_way][sw_set] <= sw_data;
            else
               mword[sw_way][sw_set] <= sw_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_paddr      <= '0;
         rsp_ci         <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_miss       <= 1'b0;
         rsp_fault      <= 1'b0;
         rsp_fault_addr <= '0;
         rsp_victim     <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_paddr      <= n_paddr;
            rsp_ci         <= n_ci;
            rsp_hit        <= n_hit;
            rsp_miss       <= n_miss;
            rsp_fault      <= n_fault;
            rsp_fault_addr <= n_faddr;
            rsp_victim     <= n_victim;
         end
      end
   end

   // R10
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R10
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R1
   bypass_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !(xlate_en && mmu_present)) |=>
         (rsp_paddr == $past(req_vaddr)) && (rsp_ci == $past(req_vaddr[VADDR_W-1])));
   // R9
   probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_probe) |=> (!rsp_miss && !rsp_fault));
   // R6
   miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> ((rsp_paddr == '0) && !rsp_fault && !rsp_hit));
endmodule

// File: tb/tb_dtlb_xlate.sv
module tb_dtlb_xlate;
   logic        clk, rst_n;
   logic        xlate_en, mmu_present;
   logic        req_valid, req_write, req_super, req_probe;
   logic [31:0] req_vaddr;
   logic        sw_we, sw_sel_tr;
   logic [1:0]  sw_way, sw_set;
   logic [31:0] sw_data;
   logic        rsp_valid, rsp_ci, rsp_hit, rsp_miss, rsp_fault;
   logic [31:0] rsp_paddr, rsp_fault_addr, cfg_word;
   logic [1:0]  rsp_victim;

   dtlb_xlate dut (
      .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .mmu_present(mmu_present),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
      .req_super(req_super), .req_probe(req_probe),
      .sw_we(sw_we), .sw_way(sw_way), .sw_set(sw_set), .sw_sel_tr(sw_sel_tr),
      .sw_data(sw_data),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_fault_addr(rsp_fault_addr), .rsp_victim(rsp_victim), .cfg_word(cfg_word)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   typedef struct packed {
      logic [31:0] paddr;
      logic        ci;
      logic        hit;
      logic        miss;
      logic        fault;
      logic [31:0] faddr;
      logic [1:0]  victim;
   } exp_t;

   exp_t        q[$];
   string       qt[$];
   int          total = 0;
   int          bad   = 0;
   bit          done  = 0;
   logic        issued_last;
   logic [31:0] bm_m [4][4];
   logic [31:0] bm_t [4][4];

   task automatic chk(string r, string what, logic [31:0] act, logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", r, what, act, expv);
      end
   endtask

   task automatic model_clear();
      for (int w = 0; w < 4; w++)
         for (int s = 0; s < 4; s++) begin
            bm_m[w][s] = '0;
            bm_t[w][s] = '0;
         end
   endtask

   // driver: predicts from the requirements and queues the expectation
   task automatic issue(string r, logic [31:0] va, logic wr, logic su, logic pr,
                        logic en = 1'b1, logic pres = 1'b1);
      exp_t       e;
      int         st, hw, vw, pb;
      logic [1:0] best;
      logic       ok;
      e  = '0;
      hw = -1;
      if (!(en && pres)) begin
         e.paddr = va;
         e.ci    = va[31];
      end else begin
         st = int'(va[14:13]);
         for (int w = 3; w >= 0; w--)
            if (bm_m[w][st][0] && (bm_m[w][st][31:15] == va[31:15])) hw = w;
         vw   = 0;
         best = bm_m[0][st][7:6];
         for (int w = 1; w < 4; w++)
            if (bm_m[w][st][7:6] < best) begin
               best = bm_m[w][st][7:6];
               vw   = w;
            end
         e.victim = 2'(vw);
         if (hw < 0) begin
            if (!pr) begin
               e.miss  = 1'b1;
               e.faddr = va;
            end
         end else begin
            pb    = su ? (wr ? 9 : 8) : (wr ? 7 : 6);
            ok    = bm_t[hw][st][pb];
            e.hit = 1'b1;
            if (ok || !pr) begin
               e.paddr = {bm_t[hw][st][31:13], va[12:0]};
               e.ci    = bm_t[hw][st][1];
            end
            if (!pr && !ok) begin
               e.fault = 1'b1;
               e.faddr = va;
            end
            if (!pr)
               for (int w = 0; w < 4; w++) begin
                  if (w == hw) bm_m[w][st][7:6] = 2'd3;
                  else if (bm_m[w][st][7:6] != 2'd0)
                     bm_m[w][st][7:6] = bm_m[w][st][7:6] - 2'd1;
               end
         end
      end
      @(posedge clk);
      #2;
      req_vaddr   = va;
      req_write   = wr;
      req_super   = su;
      req_probe   = pr;
      xlate_en    = en;
      mmu_present = pres;
      req_valid   = 1'b1;
      q.push_back(e);
      qt.push_back(r);
      @(posedge clk);
      #2;
      req_valid = 1'b0;
   endtask

   task automatic sw_write(int way, int set, logic sel, logic [31:0] d);
      if (sel) bm_t[way][set] = d;
      else     bm_m[way][set] = d;
      @(posedge clk);
      #2;
      sw_we     = 1'b1;
      sw_way    = 2'(way);
      sw_set    = 2'(set);
      sw_sel_tr = sel;
      sw_data   = d;
      @(posedge clk);
      #2;
      sw_we = 1'b0;
   endtask

   always @(posedge clk or negedge rst_n)
      if (!rst_n) issued_last <= 1'b0;
      else        issued_last <= req_valid;

   // monitor: pops expectations as responses appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (issued_last || rsp_valid)
            chk("R10", "rsp_valid", {31'b0, rsp_valid}, {31'b0, issued_last});
         if (rsp_valid && q.size() > 0) begin
            exp_t  e;
            string r;
            e = q.pop_front();
            r = qt.pop_front();
            chk(r, "paddr",  rsp_paddr,               e.paddr);
            chk(r, "ci",     {31'b0, rsp_ci},         {31'b0, e.ci});
            chk(r, "hit",    {31'b0, rsp_hit},        {31'b0, e.hit});
            chk(r, "miss",   {31'b0, rsp_miss},       {31'b0, e.miss});
            chk(r, "fault",  {31'b0, rsp_fault},      {31'b0, e.fault});
            chk(r, "faddr",  rsp_fault_addr,          e.faddr);
            chk(r, "victim", {30'b0, rsp_victim},     {30'b0, e.victim});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; xlate_en = 1'b1; mmu_present = 1'b1;
      req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_super = 1'b0; req_probe = 1'b0;
      sw_we = 1'b0; sw_way = '0; sw_set = '0; sw_sel_tr = 1'b0; sw_data = '0;
      model_clear();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
      chk("R12", "cfg_word", cfg_word, 32'h0000_0013);

      issue("R11", 32'h1234_6000, 1'b0, 1'b0, 1'b0);           // empty table misses
      issue("R1",  32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      issue("R1",  32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);

      // entry A: way1 set3, full rights, uncached
      sw_write(1, 3, 1'b0, 32'h1234_6001);
      sw_write(1, 3, 1'b1, 32'hABCD_E3C2);
      issue("R4",  32'h1234_6123, 1'b0, 1'b0, 1'b0);
      issue("R4",  32'h1234_7FFF, 1'b1, 1'b1, 1'b0);
      issue("R2",  32'h1235_6000, 1'b0, 1'b0, 1'b0);           // tag differs
      issue("R2",  32'h1234_4000, 1'b0, 1'b0, 1'b0);           // set differs
      issue("R1",  32'h1234_6000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

      // entry B: way0 set0, user read only
      sw_write(0, 0, 1'b0, 32'h4000_0001);
      sw_write(0, 0, 1'b1, 32'h0765_4040);
      issue("R5",  32'h4000_0ABC, 1'b0, 1'b0, 1'b0);
      issue("R5",  32'h4000_0ABC, 1'b1, 1'b0, 1'b0);
      issue("R5",  32'h4000_0004, 1'b0, 1'b1, 1'b0);
      issue("R5",  32'h4000_0008, 1'b1, 1'b1, 1'b0);
      issue("R9",  32'h4000_0010, 1'b1, 1'b0, 1'b1);
      issue("R9",  32'h4000_0014, 1'b0, 1'b0, 1'b1);
      issue("R9",  32'h4400_0000, 1'b0, 1'b0, 1'b1);           // probe miss
      sw_write(0, 0, 1'b1, 32'h0765_4200);                     // supervisor write only
      issue("R5",  32'h4000_0020, 1'b1, 1'b1, 1'b0);
      issue("R5",  32'h4000_0024, 1'b0, 1'b0, 1'b0);

      // entry D: way1 set0, cached although above the midpoint
      sw_write(1, 0, 1'b0, 32'h9000_0001);
      sw_write(1, 0, 1'b1, 32'h0010_03C0);
      issue("R4",  32'h9000_1000, 1'b0, 1'b1, 1'b0);

      // set2: two matching ways and preset counters
      sw_write(0, 2, 1'b0, 32'h0000_00C0);                     // invalid, age 3
      sw_write(1, 2, 1'b0, 32'h0000_0080);                     // invalid, age 2
      sw_write(2, 2, 1'b0, 32'h5000_4041);                     // valid, age 1
      sw_write(3, 2, 1'b0, 32'h5000_4041);                     // valid, age 1
      sw_write(2, 2, 1'b1, 32'h1111_23C0);
      sw_write(3, 2, 1'b1, 32'h2222_43C2);
      issue("R3",  32'h5000_4010, 1'b0, 1'b0, 1'b0);
      issue("R8",  32'h6000_4000, 1'b0, 1'b0, 1'b0);
      issue("R6",  32'h6000_4004, 1'b1, 1'b0, 1'b0);
      issue("R9",  32'h5000_4000, 1'b0, 1'b0, 1'b1);
      issue("R7",  32'h5000_4020, 1'b0, 1'b1, 1'b0);
      issue("R7",  32'h6000_4008, 1'b0, 1'b0, 1'b0);
      sw_write(2, 2, 1'b0, 32'h5000_40C0);                     // drop way2
      issue("R3",  32'h5000_4030, 1'b0, 1'b0, 1'b0);
      issue("R8",  32'h6000_400C, 1'b0, 1'b0, 1'b0);

      // reset again clears every entry
      @(posedge clk);
      #2 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #2 rst_n = 1'b1;
      model_clear();
      issue("R11", 32'h1234_6123, 1'b0, 1'b0, 1'b0);
      issue("R11", 32'h5000_4010, 1'b0, 1'b0, 1'b0);

      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R10", "responses outstanding", 32'(q.size()), 32'h0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule